// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port

This block controls a bank of general-purpose pins. Each pin has a direction bit and an output-latch bit, held in two registers on a small register bus. From these bits and a global pull-up kill input, the block works out, for each pin, whether the pad drives, what level it drives, and whether its weak pull-up is on. It also has a third register address, the pin register, which has two roles. A read returns the pad levels after a metastability synchronizer. A write does not store anything: every bit written as one inverts the matching output-latch bit.

The pad inputs first pass through a level-sensitive latch, which is open while the clock is high and closed while it is low. The latch feeds a rising-edge register. A pad change therefore reaches the pin register about one clock period later, and never more than two rising edges later. The bus decodes addresses combinationally. Writes take effect on the rising edge where the write enable is seen.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output-latch registers read zero. Every pin is a tri-state input: pad_oe, pad_out and pad_pu are all zero.
- R2: A write with bus_we high to address 1 loads the direction register, and a write to address 2 loads the output-latch register. Reads of these addresses return the current contents on bus_rdata in the same cycle.
- R3: For each bit, pad_oe equals the direction bit and pad_out equals the output-latch bit. A direction of 1 means output: latch 0 drives low and latch 1 drives high.
- R4: For each bit, pad_pu is 1 only when direction is 0, the output latch is 1 and pullup_off is 0. Direction 1 turns the pull-up off, an output-latch bit of 0 turns it off, and pullup_off high turns off every pull-up.
- R5: A write to address 0 inverts each output-latch bit whose written data bit is 1 and leaves the others unchanged. This holds whatever the direction bits are, and the direction register does not change.
- R6: A read of address 0 returns the synchronized pad_in level whatever the direction bits are. A pad change is visible there no later than two rising clock edges after it occurs.
- R7: A cycle with bus_we low changes no register. A write to address 3 changes no register, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the synchronizer latch is open while it is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin, 1 direction, 2 output latch, 3 unused |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| pullup_off | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output level per pin |
| pad_pu | output | 8 | Pad pull-up enable per pin |

## Verification
The bench builds the port at its default width of eight bits. At that width every one of the eight direction, latch and disable combinations can be swept across all pins at once. Toggle masks can be tried against several latch and direction patterns, and single-bit walking patterns on the pads show that each synchronizer lane is separate from the others. The small address space also lets the bench try the unused address for both reads and writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_LAT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level
);
    logic [W-1:0] hold_q;
    logic [W-1:0] sync_d, sync_q;

    // Open while the clock is high and closed while it is low.
    always_latch begin
        if (clk) hold_q <= pad_in;
    end

    always_comb begin
        sync_d = hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q;

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic         pullup_off,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = dir[i];
            pad_out[i] = lat[i];
            pad_pu[i]  = 1'b0;
            if (!dir[i] && lat[i] && !pullup_off) pad_pu[i] = 1'b1;
        end
    end

    a_r4_no_pu_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);
    a_r4_global_kill: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_off |-> (pad_pu == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_level,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      lat
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
    } regs_t;

    regs_t r_d, r_q;
    sel_e  sel;

    always_comb begin
        sel = sel_e'(bus_addr);
        r_d = r_q;
        if (bus_we) begin
            unique case (sel)
                SEL_PIN:  r_d.lat = r_q.lat ^ bus_wdata;
                SEL_DIR:  r_d.dir = bus_wdata;
                SEL_LAT:  r_d.lat = bus_wdata;
                SEL_NONE: r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (sel)
            SEL_PIN:  bus_rdata = pin_level;
            SEL_DIR:  bus_rdata = r_q.dir;
            SEL_LAT:  bus_rdata = r_q.lat;
            SEL_NONE: bus_rdata = '0;
        endcase
    end

    assign dir = r_q.dir;
    assign lat = r_q.lat;

    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> (dir == $past(bus_wdata)));
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> (lat == ($past(lat) ^ $past(bus_wdata))) && $stable(dir));
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || bus_addr == 2'd3) |=> ($stable(dir) && $stable(lat)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              pullup_off,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);
    logic [W-1:0] level, dir, lat;

    gpio_in_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pin_level (level),
        .bus_rdata (bus_rdata),
        .dir       (dir),
        .lat       (lat)
    );

    gpio_pad_ctrl #(.W(W)) u_pads (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir        (dir),
        .lat        (lat),
        .pullup_off (pullup_off),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    a_r3_lat_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2) |=> (pad_out == $past(bus_wdata)));

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int W   = 8;
    localparam int CLK = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         pullup_off = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK/2) clk = ~clk;

    gpio_port #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_off(pullup_off),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [W-1:0] v, lat_m, dir_m;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd1, v); chk("R1 dir reset", v, '0);
        rd(2'd2, v); chk("R1 lat reset", v, '0);
        chk("R1 oe reset", pad_oe, '0);
        chk("R1 out reset", pad_out, '0);
        chk("R1 pu reset", pad_pu, '0);
        rst_n = 1'b1;

        // R2 write and read back
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 dir readback", v, 8'hA5);
        wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 lat readback", v, 8'h3C);
        chk("R3 oe pattern", pad_oe, 8'hA5);
        chk("R3 out pattern", pad_out, 8'h3C);

        // R3/R4 truth table over all combinations, applied to every pin
        for (int c = 0; c < 8; c++) begin
            dir_m = c[2] ? '1 : '0;
            lat_m = c[1] ? '1 : '0;
            wr(2'd1, dir_m);
            wr(2'd2, lat_m);
            pullup_off = c[0];
            #1;
            chk("R3 oe table", pad_oe, dir_m);
            chk("R3 out table", pad_out, lat_m);
            chk("R4 pu table", pad_pu, (!c[2] && c[1] && !c[0]) ? '1 : '0);
        end
        pullup_off = 1'b0;
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); #1;
        chk("R4 pu mixed", pad_pu, ~8'hA5 & 8'h3C);
        pullup_off = 1'b1; #1;
        chk("R4 pu mixed killed", pad_pu, '0);
        pullup_off = 1'b0;

        // R5 toggle via pin address under several patterns
        for (int k = 0; k < 16; k++) begin
            dir_m = 8'(k * 37);
            lat_m = 8'(k * 91 + 5);
            v = 8'(k * 29 + 1);
            wr(2'd1, dir_m);
            wr(2'd2, lat_m);
            wr(2'd0, v);
            chk("R5 toggle lat", pad_out, lat_m ^ v);
            chk("R5 dir kept", pad_oe, dir_m);
        end

        // R7 we low and address 3
        wr(2'd1, 8'h0F); wr(2'd2, 8'hF0);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h99; bus_we = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(2'd1, v); chk("R7 no-we dir", v, 8'h0F);
        wr(2'd3, 8'h77);
        rd(2'd1, v); chk("R7 addr3 dir", v, 8'h0F);
        rd(2'd2, v); chk("R7 addr3 lat", v, 8'hF0);
        rd(2'd3, v); chk("R7 addr3 read", v, '0);

        // R6 synchronized pad read, walking pattern, with both directions
        for (int d = 0; d < 2; d++) begin
            wr(2'd1, d[0] ? '1 : '0);
            for (int i = 0; i < W + 1; i++) begin
                @(negedge clk);
                pad_in = (i == W) ? 8'h5A : (8'h1 << i);
                @(posedge clk); @(posedge clk);
                #(CLK/4);
                rd(2'd0, v);
                chk("R6 pin level", v, pad_in);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * CLK);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule